// File: doc/BRIEF.md
# Matrix Keypad Capture Controller

This block gathers key events from an up-to-8x8 key matrix into four capture words and signals software with a level interrupt. Each event carries a row, a column and a press/release flag. Physical scanning, debounce timing, rotary counting and direct-key sampling all happen outside the block. The block keeps the registers that software expects for those functions. Some of them are plain storage. Others have flags that clear when read.

Key events arrive on a valid/ready stream. Ready is held high at all times, so the block never applies back-pressure. An event is consumed in any cycle in which valid is high. Software reaches the registers through a single-cycle word bus: a request with a write flag, an 8-bit byte offset and 32-bit data. Read data is combinational in the cycle of the request. Any side effect of a read lands at the clock edge that ends the request.

Top module: `kp_matrix_capture`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: A write to a mapped offset loads all 32 bits, and a later read returns them. The mapped offsets are: control 0x00, direct-key 0x08, rotary 0x10, matrix-key 0x18, scan 0x20, capture words 0..3 at 0x28/0x30/0x38/0x40, and debounce 0x48.
- R3: A read of an offset that is not 8-byte aligned, or that lies above 0x48, returns zero. A write to such an offset changes no register.
- R4: A key event is dropped unless two conditions hold. Control bit 12 (matrix enable) must be set. At least one of control bit 30 (scan request) or bit 29 (scan on activity) must also be set. A dropped event changes no capture word and does not raise `irq`.
- R5: An accepted press at (row, col) sets bit row+16*(col mod 2) in capture word col/2. It leaves the other bits as they are, so presses accumulate.
- R6: An accepted release at any row of column col clears the whole capture word col/2. The other capture words keep their values.
- R7: An accepted event clears control bit 30 and leaves bit 29 unchanged.
- R8: If control bit 11 (interrupt enable) is set, an accepted event sets control bit 22 (matrix interrupt) and drives `irq` high. If bit 11 is clear, neither bit 22 nor `irq` changes.
- R9: A read of control returns its value from before the read. Control bits 22 and 5 (direct interrupt) then clear, and `irq` drops.
- R10: A read of the rotary register returns its value and then clears bits 31, 30, 15 and 14. A read of the matrix-key register clears its bit 31. All other bits are kept.
- R11: If an accepted, interrupt-enabled event and a control read happen in the same cycle, the read returns the old value. Bit 22 ends up set and `irq` stays high.
- R12: `key_ready` is high in every cycle, and the block never stalls the key stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | Key event present |
| key_ready | output | 1 | Event accepted; always high |
| key_row | input | 3 | Matrix row of the event |
| key_col | input | 3 | Matrix column of the event |
| key_release | input | 1 | 1 = release, 0 = press |
| bus_req | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq | output | 1 | Level matrix interrupt |

## Verification
A key event and a bus read of the control register can land in the same cycle. The read then wants to clear the interrupt status, while the event wants to set it. The bench drives both stimuli in one cycle. It checks that the returned word still shows the pre-event value, that `irq` stays high afterwards, and that a following control read shows bit 22 set and only then lets `irq` fall. The opposite cases are also covered: a read with no event drops `irq`, and an event with no read raises it.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_DW    = 32;
  localparam int KP_NREG  = 10;
  localparam int KP_IDX_W = 4;

  // register slot indices (byte offset = index * 8)
  localparam int IX_CTRL   = 0;
  localparam int IX_DIRECT = 1;
  localparam int IX_ROTARY = 2;
  localparam int IX_MATRIX = 3;
  localparam int IX_SCAN   = 4;
  localparam int IX_CAP0   = 5;
  localparam int IX_DEBNC  = 9;

  // control bit positions
  localparam int CB_SCAN_REQ = 30;
  localparam int CB_SCAN_ACT = 29;
  localparam int CB_MINT     = 22;
  localparam int CB_MEN      = 12;
  localparam int CB_MIE      = 11;
  localparam int CB_DINT     = 5;

  typedef logic [KP_IDX_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     hit;
    logic     rd;
    logic     wr;
    reg_idx_t idx;
  } bus_op_t;

  // bits cleared by a read of a plain register slot
  function automatic logic [KP_DW-1:0] kp_rdclr_mask(int idx);
    logic [KP_DW-1:0] m;
    m = '0;
    if (idx == IX_ROTARY) begin
      m[31] = 1'b1; m[30] = 1'b1; m[15] = 1'b1; m[14] = 1'b1;
    end else if (idx == IX_MATRIX) begin
      m[31] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/kp_bus_decode.sv
module kp_bus_decode
  import kp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  output bus_op_t       op
);
  localparam int SLOT_W = AW - 3;

  logic [SLOT_W-1:0] slot;
  logic              aligned;
  logic              in_map;

  assign slot    = bus_addr[AW-1:3];
  assign aligned = (bus_addr[2:0] == 3'b000);
  assign in_map  = (int'(slot) < KP_NREG);

  always_comb begin
    op.hit = bus_req && aligned && in_map;
    op.rd  = bus_req && !bus_wr;
    op.wr  = bus_req && bus_wr;
    op.idx = slot[KP_IDX_W-1:0];
  end
endmodule

// File: rtl/kp_event_route.sv
module kp_event_route
  import kp_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 32,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int NCAP  = COLS / 2
) (
  input  logic             key_fire,
  input  logic [ROW_W-1:0] key_row,
  input  logic [COL_W-1:0] key_col,
  input  logic             key_release,
  input  logic             men,
  input  logic             scan_req,
  input  logic             scan_act,
  input  logic             mie,
  output logic             accept,
  output logic             raise,
  output logic [NCAP-1:0]  cap_sel,
  output logic [DW-1:0]    set_mask,
  output logic             wipe
);
  localparam int HALF = 16;

  logic [COL_W-2:0] pair;
  int               bitpos;

  assign accept = key_fire && men && (scan_req || scan_act);
  assign raise  = accept && mie;
  assign wipe   = key_release;
  assign pair   = key_col[COL_W-1:1];

  always_comb begin
    bitpos   = int'(key_row) + (key_col[0] ? HALF : 0);
    set_mask = DW'(1) << bitpos;
  end

  for (genvar g = 0; g < NCAP; g++) begin : g_sel
    assign cap_sel[g] = accept && (int'(pair) == g);
  end
endmodule

// File: rtl/kp_capture_bank.sv
module kp_capture_bank #(
  parameter int NCAP = 4,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCAP-1:0]          cap_sel,
  input  logic [DW-1:0]            set_mask,
  input  logic                     wipe,
  input  logic [NCAP-1:0]          wr_sel,
  input  logic [DW-1:0]            wdata,
  output logic [NCAP-1:0][DW-1:0]  cap_q
);
  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n)          cap_q[g] <= '0;
      else if (wr_sel[g])  cap_q[g] <= wdata;
      else if (cap_sel[g]) cap_q[g] <= wipe ? '0 : (cap_q[g] | set_mask);
    end
  end
endmodule

// File: rtl/kp_reg_file.sv
module kp_reg_file
  import kp_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NCAP = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  bus_op_t                     op,
  input  logic [DW-1:0]               wdata,
  input  logic                        accept,
  input  logic                        raise,
  output logic [DW-1:0]               ctrl_q,
  output logic                        irq,
  output logic [KP_NREG-1:0][DW-1:0]  plain_q
);
  logic ctrl_wr, ctrl_rd;
  logic [DW-1:0] ctrl_d;

  assign ctrl_wr = op.hit && op.wr && (int'(op.idx) == IX_CTRL);
  assign ctrl_rd = op.hit && op.rd && (int'(op.idx) == IX_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = wdata;
    end else begin
      if (ctrl_rd) begin
        ctrl_d[CB_MINT] = 1'b0;
        ctrl_d[CB_DINT] = 1'b0;
      end
      if (accept) ctrl_d[CB_SCAN_REQ] = 1'b0;
      if (raise)  ctrl_d[CB_MINT]     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq    <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (raise)        irq <= 1'b1;
      else if (ctrl_rd) irq <= 1'b0;
    end
  end

  for (genvar g = 0; g < KP_NREG; g++) begin : g_plain
    if (g == IX_CTRL || (g >= IX_CAP0 && g < IX_CAP0 + NCAP)) begin : g_none
      assign plain_q[g] = '0;
    end else begin : g_reg
      localparam logic [DW-1:0] CLR = DW'(kp_rdclr_mask(g));
      logic sel;
      assign sel = op.hit && (int'(op.idx) == g);
      always_ff @(posedge clk) begin
        if (!rst_n)             plain_q[g] <= '0;
        else if (sel && op.wr)  plain_q[g] <= wdata;
        else if (sel && op.rd)  plain_q[g] <= plain_q[g] & ~CLR;
      end
    end
  end
endmodule

// File: rtl/kp_matrix_capture.sv
module kp_matrix_capture
  import kp_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int AW   = 8,
  parameter int DW   = KP_DW,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int NCAP  = COLS / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [ROW_W-1:0] key_row,
  input  logic [COL_W-1:0] key_col,
  input  logic             key_release,
  input  logic             bus_req,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  bus_op_t                     op;
  logic                        key_fire;
  logic                        accept, raise, wipe;
  logic [NCAP-1:0]             cap_sel, cap_wr;
  logic [DW-1:0]               set_mask;
  logic [DW-1:0]               ctrl_q;
  logic [NCAP-1:0][DW-1:0]     cap_q;
  logic [KP_NREG-1:0][DW-1:0]  plain_q;

  assign key_ready = 1'b1;
  assign key_fire  = key_valid && key_ready;

  kp_bus_decode #(.AW(AW)) u_dec (
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .op(op)
  );

  kp_event_route #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_route (
    .key_fire(key_fire), .key_row(key_row), .key_col(key_col),
    .key_release(key_release),
    .men(ctrl_q[CB_MEN]), .scan_req(ctrl_q[CB_SCAN_REQ]),
    .scan_act(ctrl_q[CB_SCAN_ACT]), .mie(ctrl_q[CB_MIE]),
    .accept(accept), .raise(raise), .cap_sel(cap_sel),
    .set_mask(set_mask), .wipe(wipe)
  );

  for (genvar g = 0; g < NCAP; g++) begin : g_capwr
    assign cap_wr[g] = op.hit && op.wr && (int'(op.idx) == IX_CAP0 + g);
  end

  kp_capture_bank #(.NCAP(NCAP), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_sel(cap_sel), .set_mask(set_mask),
    .wipe(wipe), .wr_sel(cap_wr), .wdata(bus_wdata), .cap_q(cap_q)
  );

  kp_reg_file #(.DW(DW), .NCAP(NCAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .op(op), .wdata(bus_wdata),
    .accept(accept), .raise(raise), .ctrl_q(ctrl_q), .irq(irq),
    .plain_q(plain_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (op.hit && op.rd) begin
      if (int'(op.idx) == IX_CTRL)
        bus_rdata = ctrl_q;
      else if (int'(op.idx) >= IX_CAP0 && int'(op.idx) < IX_CAP0 + NCAP)
        bus_rdata = cap_q[int'(op.idx) - IX_CAP0];
      else
        bus_rdata = plain_q[op.idx];
    end
  end
endmodule

// File: rtl/kp_capture_checker.sv
module kp_capture_checker
  import kp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NCAP  = 4,
  parameter int COL_W = 3,
  parameter int AW    = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    key_valid,
  input logic                    key_ready,
  input logic [COL_W-1:0]        key_col,
  input logic                    key_release,
  input logic                    bus_req,
  input logic                    bus_wr,
  input logic [AW-1:0]           bus_addr,
  input logic [DW-1:0]           ctrl_q,
  input logic [NCAP-1:0][DW-1:0] cap_q,
  input logic                    irq
);
  logic acc, rais, ctl_rd, any_wr;
  logic [COL_W-2:0] pair_q;

  assign acc    = key_valid && key_ready && ctrl_q[CB_MEN] &&
                  (ctrl_q[CB_SCAN_REQ] || ctrl_q[CB_SCAN_ACT]);
  assign rais   = acc && ctrl_q[CB_MIE];
  assign ctl_rd = bus_req && !bus_wr && (bus_addr == '0);
  assign any_wr = bus_req && bus_wr;

  always_ff @(posedge clk) pair_q <= key_col[COL_W-1:1];

  // R4: irq only rises through an accepted, enabled event
  a_r4_no_spurious_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !rais) |=> !irq);
  // R8
  a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    rais |=> irq);
  // R9
  a_r9_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !rais) |=> !irq);
  // R11
  a_r11_event_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && rais) |=> (irq && ctrl_q[CB_MINT]));
  // R7
  a_r7_scan_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !any_wr) |=> !ctrl_q[CB_SCAN_REQ]);
  // R6
  a_r6_release_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && key_release && !any_wr) |=> (cap_q[pair_q] == '0));
  // R12
  a_r12_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> key_ready);
endmodule

bind kp_matrix_capture kp_capture_checker #(
  .DW(DW), .NCAP(NCAP), .COL_W(COL_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
  .key_col(key_col), .key_release(key_release), .bus_req(bus_req),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .ctrl_q(ctrl_q), .cap_q(cap_q),
  .irq(irq)
);

// File: tb/sim_kp_matrix_capture.sv
module sim_kp_matrix_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_valid = 1'b0, key_release = 1'b0;
  logic        key_ready;
  logic [2:0]  key_row = '0, key_col = '0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  kp_matrix_capture u0 (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_row(key_row), .key_col(key_col), .key_release(key_release),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && bus_req && !bus_wr) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read: actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic drive(bit breq, bit bwr, logic [7:0] a, logic [31:0] d,
                       bit kv, int r, int c, bit rel);
    @(posedge clk); #1;
    bus_req = breq; bus_wr = bwr; bus_addr = a; bus_wdata = d;
    key_valid = kv; key_row = 3'(r); key_col = 3'(c); key_release = rel;
  endtask

  task automatic idle();
    drive(0, 0, 8'h00, 32'h0, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    drive(1, 1, a, d, 0, 0, 0, 0);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    drive(1, 0, a, 32'h0, 0, 0, 0, 0);
  endtask

  task automatic key(int r, int c, bit rel);
    drive(0, 0, 8'h00, 32'h0, 1, r, c, rel);
  endtask

  task automatic chk(logic act, logic e, string t);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", t, act, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 10; i++) rd(8'(i * 8), 32'h0, "R1 reset value");
    idle();
    chk(irq, 1'b0, "R1 irq after reset");

    // R2 full-word storage
    wr(8'h08, 32'hA5A5_0001);
    wr(8'h20, 32'h1234_5678);
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h38, 32'h0F0F_0F0F);
    rd(8'h08, 32'hA5A5_0001, "R2 direct");
    rd(8'h20, 32'h1234_5678, "R2 scan");
    rd(8'h48, 32'hFFFF_FFFF, "R2 debounce");
    rd(8'h38, 32'h0F0F_0F0F, "R2 capture2");
    wr(8'h38, 32'h0);

    // R3 unmapped offsets
    wr(8'h04, 32'hDEAD_0000);
    wr(8'h50, 32'hBEEF_0000);
    wr(8'h0C, 32'h0000_1111);
    rd(8'h04, 32'h0, "R3 misaligned read");
    rd(8'h50, 32'h0, "R3 above map");
    rd(8'hF8, 32'h0, "R3 top offset");
    rd(8'h08, 32'hA5A5_0001, "R3 neighbour kept");
    rd(8'h00, 32'h0, "R3 ctrl kept");

    // R4 dropped events
    key(1, 2, 0); idle();
    chk(irq, 1'b0, "R4 ctrl zero irq");
    rd(8'h30, 32'h0, "R4 ctrl zero capture");
    wr(8'h00, 32'h0000_1800);           // enable + irq enable, no scan mode
    key(1, 2, 0); idle();
    chk(irq, 1'b0, "R4 no scan mode irq");
    rd(8'h30, 32'h0, "R4 no scan mode capture");
    wr(8'h00, 32'h2000_0800);           // scan on activity, no enable
    key(1, 2, 0); idle();
    chk(irq, 1'b0, "R4 disabled irq");
    rd(8'h30, 32'h0, "R4 disabled capture");

    // R5 R7 R8 R9 with scan request
    wr(8'h00, 32'h4000_1800);
    key(3, 0, 0); idle();
    chk(irq, 1'b1, "R8 irq raised");
    rd(8'h28, 32'h0000_0008, "R5 press r3 c0");
    rd(8'h00, 32'h0040_1800, "R7 R8 R9 ctrl pre-clear value");
    idle();
    chk(irq, 1'b0, "R9 irq dropped");
    rd(8'h00, 32'h0000_1800, "R9 status cleared");

    // R5 accumulation, scan on activity
    wr(8'h00, 32'h2000_1800);
    key(5, 1, 0);
    key(7, 7, 0);
    key(0, 6, 0);
    rd(8'h28, 32'h0020_0008, "R5 odd column upper half");
    rd(8'h40, 32'h0080_0001, "R5 capture3 accumulate");
    rd(8'h00, 32'h2040_1800, "R7 activity bit kept");
    idle();
    chk(irq, 1'b0, "R9 irq dropped again");

    // R6 release wipes word
    key(2, 7, 1); idle();
    chk(irq, 1'b1, "R8 release raises irq");
    rd(8'h40, 32'h0, "R6 capture3 wiped");
    rd(8'h28, 32'h0020_0008, "R6 capture0 kept");
    rd(8'h00, 32'h2040_1800, "R6 ctrl status");

    // R8 without interrupt enable
    wr(8'h00, 32'h2000_1000);
    key(4, 2, 0); idle();
    chk(irq, 1'b0, "R8 no irq when disabled");
    rd(8'h30, 32'h0000_0010, "R5 capture1 press");
    rd(8'h00, 32'h2000_1000, "R8 no status when disabled");

    // R9 direct interrupt bit clears on read
    wr(8'h00, 32'h2040_1020);
    rd(8'h00, 32'h2040_1020, "R9 written status");
    rd(8'h00, 32'h2000_1000, "R9 both status bits cleared");
    idle();
    chk(irq, 1'b0, "R9 writes leave irq low");

    // R10 read-clear flags
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'hFFFF_FFFF, "R10 rotary first read");
    rd(8'h10, 32'h3FFF_3FFF, "R10 rotary flags cleared");
    wr(8'h18, 32'h8000_0003);
    rd(8'h18, 32'h8000_0003, "R10 matrix first read");
    rd(8'h18, 32'h0000_0003, "R10 matrix flag cleared");

    // R11 event and control read in the same cycle
    wr(8'h00, 32'h2000_1800);
    exp_q.push_back(32'h2000_1800); tag_q.push_back("R11 read sees old value");
    drive(1, 0, 8'h00, 32'h0, 1, 1, 4, 0);
    idle();
    chk(irq, 1'b1, "R11 irq kept high");
    rd(8'h00, 32'h2040_1800, "R11 status set");
    idle();
    chk(irq, 1'b0, "R11 later read drops irq");
    rd(8'h38, 32'h0000_0002, "R11 capture2 press");

    // R12 ready
    drive(0, 0, 8'h00, 32'h0, 1, 0, 0, 0);
    chk(key_ready, 1'b1, "R12 ready with valid");
    idle();
    chk(key_ready, 1'b1, "R12 ready idle");

    idle();
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule